// File: doc/BRIEF.md
# Strap latch and pin-mode controller

This block decides, shortly after reset, how a connector-control device presents itself to the system. It reads two three-level straps that have already been resolved into a two-bit level code. The address strap selects between a register-access mode, where a host reaches the device over a serial bus, and an autonomous mode with no bus. In register-access mode it also sets bit 6 of the bus address. The port strap selects the initial power role: host, device or dual-role.

The straps are sampled once a parameterised settling count expires after reset release. From then on the block drives the shared pins. The address-strap pin becomes a connection-detect output. In autonomous mode the two bus pins carry the detected supply-current level and a third pin flags an analog audio accessory. In register-access mode the bus pins are left to the bus and the third pin carries the active-low interrupt. Open-drain pins are modelled as an output enable: enable high means the pin is pulled low, and the data value is always low.

The role follows the port strap continuously in autonomous mode. In register-access mode the role is frozen at sampling time and changes only through a register write.

Top module: `strap_pin_ctrl`

## Requirements
- R1: `strap_ready` is 0 after reset. It rises on the LATCH_CYCLES-th rising clock edge after reset release and then stays 1 until the next reset.
- R2: While `strap_ready` is 0, `reg_mode`, `addr_bit6`, every pin output enable and `eff_role` are 0 (`eff_role` 0 means device).
- R3: Level codes are 00 = low, 01 = high, 10 = mid, and 11 = floating, which is treated as mid. An address strap of high or low gives `reg_mode`=1, with `addr_bit6`=1 for high and 0 for low. Mid or floating gives `reg_mode`=0 and `addr_bit6`=0. All three values hold from the sampling edge until reset.
- R4: The port strap maps to a role code: low gives device (00), high gives host (01), and mid or floating gives dual-role (10).
- R5: In register-access mode `eff_role` keeps the role sampled at the strap edge, and later port-strap changes do not affect it. A `role_wr` pulse with value 00, 01 or 10 replaces the role one cycle later. A pulse with value 11 is ignored.
- R6: In autonomous mode `eff_role` equals the role of the port strap sampled one cycle earlier. `role_wr` pulses have no effect.
- R7: From the clock edge after `strap_ready` rises, `adr_oe` is 1 in autonomous mode, whatever `condet_dis` is. In register-access mode `adr_oe` equals the inverse of `condet_dis` from one cycle earlier.
- R8: `adr_out` equals `attached` from one cycle earlier, so the pin reads high while a connection is present.
- R9: In autonomous mode, after the strap edge, the current level is encoded on the pin pair {OUT2, OUT1} as 00 = high, 10 = medium and 11 = default. Input codes are 00 = default, 01 = medium, 10 = high, and 11 is treated as default. A 0 is driven (enable 1) and a 1 is released (enable 0). The enables update one cycle after the input.
- R10: After the strap edge, `out3_oe` equals `audio_det` from one cycle earlier in autonomous mode, and `irq_req` from one cycle earlier in register-access mode.
- R11: In register-access mode `out1_oe` and `out2_oe` stay 0 so the bus pins are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_lvl | input | 2 | Resolved address-strap level (00 low, 01 high, 10 mid, 11 floating) |
| port_lvl | input | 2 | Resolved port-strap level, same coding |
| attached | input | 1 | Connection present, from the detection state machine |
| cur_level | input | 2 | Detected current level (00 default, 01 medium, 10 high) |
| audio_det | input | 1 | Analog audio accessory detected |
| irq_req | input | 1 | Interrupt request from the register file |
| role_wr | input | 1 | One-cycle role write strobe from the register file |
| role_wr_val | input | 2 | Role value written (00 device, 01 host, 10 dual-role) |
| condet_dis | input | 1 | Register bit that keeps the connection-detect pin an input (reset value 1 in the register file) |
| strap_ready | output | 1 | Straps have been sampled |
| reg_mode | output | 1 | 1 = register-access mode, 0 = autonomous |
| addr_bit6 | output | 1 | Bit 6 of the bus address |
| eff_role | output | 2 | Effective power role |
| adr_oe | output | 1 | Address pin turned into an output |
| adr_out | output | 1 | Connection-detect level on the address pin |
| out1_oe | output | 1 | Open-drain pull-down enable, OUT1 |
| out2_oe | output | 1 | Open-drain pull-down enable, OUT2 |
| out3_oe | output | 1 | Open-drain pull-down enable, OUT3 / interrupt |

## Verification
`strap_ready`, the mode, the address bit and the sampled role appear right after the LATCH_CYCLES-th edge following reset release. Every pin enable follows one edge later, because the pin register sees the registered ready flag. Every later input change reaches its output after exactly one edge. The bench drives inputs on the falling edge and reads on the next falling edge. Around the strap edge it counts falling edges from reset release, checking `strap_ready` low at LATCH_CYCLES-1, high with pins still released at LATCH_CYCLES, and pins active at LATCH_CYCLES+1.

// File: rtl/strap_pkg.sv
package strap_pkg;

    typedef enum logic [1:0] {
        LVL_LOW   = 2'b00,
        LVL_HIGH  = 2'b01,
        LVL_MID   = 2'b10,
        LVL_FLOAT = 2'b11
    } lvl_e;

    typedef enum logic [1:0] {
        ROLE_DEV  = 2'b00,
        ROLE_HOST = 2'b01,
        ROLE_DUAL = 2'b10,
        ROLE_RSVD = 2'b11
    } role_e;

    typedef enum logic [1:0] {
        CUR_DEF  = 2'b00,
        CUR_MED  = 2'b01,
        CUR_HIGH = 2'b10,
        CUR_RSVD = 2'b11
    } cur_e;

    // Port strap to power role; mid and floating both mean dual-role.
    function automatic role_e lvl_to_role(input logic [1:0] lvl);
        case (lvl)
            LVL_LOW:  return ROLE_DEV;
            LVL_HIGH: return ROLE_HOST;
            default:  return ROLE_DUAL;
        endcase
    endfunction

endpackage

// File: rtl/strap_latch_timer.sv
module strap_latch_timer #(
    parameter int LATCH_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic capture,
    output logic done
);
    localparam int CNT_W = (LATCH_CYCLES < 2) ? 1 : $clog2(LATCH_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LATCH_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d   = tmr_q;
        capture = !tmr_q.done && (tmr_q.cnt == LAST);
        if (capture) begin
            tmr_d.done = 1'b1;
        end else if (!tmr_q.done) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign done = tmr_q.done;
endmodule

// File: rtl/strap_role_sel.sv
module strap_role_sel
    import strap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture,
    input  logic       done,
    input  logic [1:0] addr_lvl,
    input  logic [1:0] port_lvl,
    input  logic       role_wr,
    input  logic [1:0] role_wr_val,
    output logic       reg_mode,
    output logic       addr_bit6,
    output logic [1:0] eff_role
);
    typedef struct packed {
        logic  reg_mode;
        logic  bit6;
        role_e role;
    } sel_t;

    sel_t sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (capture) begin
            sel_d.reg_mode = (addr_lvl == LVL_LOW) || (addr_lvl == LVL_HIGH);
            sel_d.bit6     = (addr_lvl == LVL_HIGH);
            sel_d.role     = lvl_to_role(port_lvl);
        end else if (done) begin
            if (!sel_q.reg_mode) begin
                sel_d.role = lvl_to_role(port_lvl);
            end else if (role_wr && (role_wr_val != ROLE_RSVD)) begin
                sel_d.role = role_e'(role_wr_val);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '{reg_mode: 1'b0, bit6: 1'b0, role: ROLE_DEV};
        else        sel_q <= sel_d;
    end

    assign reg_mode  = sel_q.reg_mode;
    assign addr_bit6 = sel_q.bit6;
    assign eff_role  = sel_q.role;
endmodule

// File: rtl/strap_pin_drive.sv
module strap_pin_drive
    import strap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done,
    input  logic       reg_mode,
    input  logic       condet_dis,
    input  logic       attached,
    input  logic [1:0] cur_level,
    input  logic       audio_det,
    input  logic       irq_req,
    output logic       adr_oe,
    output logic       adr_out,
    output logic       out1_oe,
    output logic       out2_oe,
    output logic       out3_oe
);
    typedef struct packed {
        logic adr_oe;
        logic adr_out;
        logic o1;
        logic o2;
        logic o3;
    } pin_t;

    pin_t pin_d, pin_q;

    always_comb begin
        pin_d         = '0;
        pin_d.adr_out = attached;
        if (done) begin
            pin_d.adr_oe = !reg_mode || !condet_dis;
            if (reg_mode) begin
                pin_d.o3 = irq_req;
            end else begin
                pin_d.o3 = audio_det;
                case (cur_level)
                    CUR_HIGH: begin pin_d.o1 = 1'b1; pin_d.o2 = 1'b1; end
                    CUR_MED:  begin pin_d.o1 = 1'b1; pin_d.o2 = 1'b0; end
                    default:  begin pin_d.o1 = 1'b0; pin_d.o2 = 1'b0; end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_d;
    end

    assign adr_oe  = pin_q.adr_oe;
    assign adr_out = pin_q.adr_out;
    assign out1_oe = pin_q.o1;
    assign out2_oe = pin_q.o2;
    assign out3_oe = pin_q.o3;
endmodule

// File: rtl/strap_pin_ctrl.sv
module strap_pin_ctrl #(
    parameter int LATCH_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] addr_lvl,
    input  logic [1:0] port_lvl,
    input  logic       attached,
    input  logic [1:0] cur_level,
    input  logic       audio_det,
    input  logic       irq_req,
    input  logic       role_wr,
    input  logic [1:0] role_wr_val,
    input  logic       condet_dis,
    output logic       strap_ready,
    output logic       reg_mode,
    output logic       addr_bit6,
    output logic [1:0] eff_role,
    output logic       adr_oe,
    output logic       adr_out,
    output logic       out1_oe,
    output logic       out2_oe,
    output logic       out3_oe
);
    logic capture;

    strap_latch_timer #(.LATCH_CYCLES(LATCH_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .done    (strap_ready)
    );

    strap_role_sel u_role (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (capture),
        .done        (strap_ready),
        .addr_lvl    (addr_lvl),
        .port_lvl    (port_lvl),
        .role_wr     (role_wr),
        .role_wr_val (role_wr_val),
        .reg_mode    (reg_mode),
        .addr_bit6   (addr_bit6),
        .eff_role    (eff_role)
    );

    strap_pin_drive u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (strap_ready),
        .reg_mode   (reg_mode),
        .condet_dis (condet_dis),
        .attached   (attached),
        .cur_level  (cur_level),
        .audio_det  (audio_det),
        .irq_req    (irq_req),
        .adr_oe     (adr_oe),
        .adr_out    (adr_out),
        .out1_oe    (out1_oe),
        .out2_oe    (out2_oe),
        .out3_oe    (out3_oe)
    );
endmodule

// File: rtl/strap_pin_chk.sv
module strap_pin_chk #(
    parameter int LATCH_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] addr_lvl,
    input logic [1:0] port_lvl,
    input logic       attached,
    input logic [1:0] cur_level,
    input logic       audio_det,
    input logic       irq_req,
    input logic       role_wr,
    input logic [1:0] role_wr_val,
    input logic       condet_dis,
    input logic       strap_ready,
    input logic       reg_mode,
    input logic       addr_bit6,
    input logic [1:0] eff_role,
    input logic       adr_oe,
    input logic       adr_out,
    input logic       out1_oe,
    input logic       out2_oe,
    input logic       out3_oe
);
    localparam int CW = $clog2(LATCH_CYCLES + 2);
    localparam logic [CW-1:0] LIM = CW'(LATCH_CYCLES);

    logic [CW-1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cyc <= '0;
        else if (cyc < LIM) cyc <= cyc + 1'b1;
    end

    assert_ready_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        strap_ready == (cyc >= LIM)) else $error("ready timing");

    assert_quiet_before_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_ready |-> !adr_oe && !out1_oe && !out2_oe && !out3_oe && !reg_mode && eff_role == 2'b00)
        else $error("pins active before strap");

    assert_mode_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strap_ready) |-> reg_mode == ($past(addr_lvl) == 2'b00 || $past(addr_lvl) == 2'b01)
                               && addr_bit6 == ($past(addr_lvl) == 2'b01))
        else $error("mode capture");

    assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        strap_ready |=> $stable(reg_mode) && $stable(addr_bit6)) else $error("mode moved");

    assert_role_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strap_ready && reg_mode && !(role_wr && role_wr_val != 2'b11) |=> $stable(eff_role))
        else $error("role moved without write");

    assert_role_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        strap_ready && !reg_mode |=> eff_role == strap_pkg::lvl_to_role($past(port_lvl)))
        else $error("role not following strap");

    assert_condet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        strap_ready && reg_mode |=> adr_oe == !$past(condet_dis)) else $error("condet enable");

    assert_condet_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> adr_out == $past(attached)) else $error("condet level");

    assert_high_cur_R9: assert property (@(posedge clk) disable iff (!rst_n)
        strap_ready && !reg_mode && cur_level == 2'b10 |=> out1_oe && out2_oe)
        else $error("high current code");

    assert_out3_R10: assert property (@(posedge clk) disable iff (!rst_n)
        strap_ready |=> out3_oe == (reg_mode ? $past(irq_req) : $past(audio_det)))
        else $error("out3 source");

    assert_bus_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_mode |-> !out1_oe && !out2_oe) else $error("bus pins driven");
endmodule

bind strap_pin_ctrl strap_pin_chk #(.LATCH_CYCLES(LATCH_CYCLES)) u_chk (.*);

// File: tb/sim_strap_pin_ctrl.sv
`timescale 1ns/1ps
module sim_strap_pin_ctrl;
    localparam int LAT = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] addr_lvl = 2'b10, port_lvl = 2'b10, cur_level = 2'b00, role_wr_val = 2'b00;
    logic attached = 1'b0, audio_det = 1'b0, irq_req = 1'b0, role_wr = 1'b0, condet_dis = 1'b1;
    logic strap_ready, reg_mode, addr_bit6, adr_oe, adr_out, out1_oe, out2_oe, out3_oe;
    logic [1:0] eff_role;

    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    strap_pin_ctrl #(.LATCH_CYCLES(LAT)) u0 (.*);

    // {port, cur, audio, attached, exp_role, exp_o1, exp_o2, exp_o3, exp_adr}
    localparam logic [11:0] VEC [0:5] = '{
        12'b01_00_0_1_01_0_0_0_1,
        12'b00_10_1_0_00_1_1_1_0,
        12'b10_01_0_1_10_1_0_0_1,
        12'b11_11_1_1_10_0_0_1_1,
        12'b01_10_0_0_01_1_1_0_0,
        12'b00_01_1_1_00_1_0_1_1
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Reset with the given straps, then wait until just before the strap edge.
    task automatic boot(input logic [1:0] a, input logic [1:0] p);
        rst_n = 1'b0; addr_lvl = a; port_lvl = p;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (LAT - 1) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R2: reset state
        @(negedge clk);
        check("R2 reset outputs", {strap_ready, reg_mode, addr_bit6, adr_oe}, 4'h0);
        check("R2 reset pins", {out1_oe, out2_oe, out3_oe, |eff_role}, 4'h0);

        // Autonomous boot, port high
        audio_det = 1'b1; cur_level = 2'b10; attached = 1'b1;
        boot(2'b10, 2'b01);
        check("R1 not ready at LAT-1", {3'b0, strap_ready}, 4'h0);
        @(negedge clk);
        check("R1 ready at LAT", {3'b0, strap_ready}, 4'h1);
        check("R2 pins idle on strap edge", {adr_oe, out1_oe, out2_oe, out3_oe}, 4'h0);
        check("R3 mid address -> autonomous", {2'b0, reg_mode, addr_bit6}, 4'h0);
        check("R4 high port -> host", {2'b0, eff_role}, 4'h1);
        @(negedge clk);
        check("R7 condet on in autonomous despite disable bit", {3'b0, adr_oe}, 4'h1);
        check("R9 R10 pins active", {1'b0, out1_oe, out2_oe, out3_oe}, 4'h7);

        // Vector walk in autonomous mode
        for (int i = 0; i < 6; i++) begin
            {port_lvl, cur_level, audio_det, attached} = VEC[i][11:6];
            @(negedge clk);
            check("R6 R4 role follows strap", {2'b0, eff_role}, {2'b0, VEC[i][5:4]});
            check("R9 current code", {2'b0, out2_oe, out1_oe}, {2'b0, VEC[i][2], VEC[i][3]});
            check("R10 audio pin", {3'b0, out3_oe}, {3'b0, VEC[i][1]});
            check("R8 condet level", {3'b0, adr_out}, {3'b0, VEC[i][0]});
        end

        // R6: writes ignored in autonomous mode (port high)
        port_lvl = 2'b01;
        @(negedge clk);
        role_wr = 1'b1; role_wr_val = 2'b00;
        @(negedge clk);
        role_wr = 1'b0;
        @(negedge clk);
        check("R6 write ignored in autonomous", {2'b0, eff_role}, 4'h1);
        check("R1 ready held", {3'b0, strap_ready}, 4'h1);

        // Register mode, address high, port low
        irq_req = 1'b1; cur_level = 2'b10; condet_dis = 1'b1;
        boot(2'b01, 2'b00);
        @(negedge clk);
        check("R3 high address", {2'b0, reg_mode, addr_bit6}, 4'h3);
        check("R4 low port -> device", {2'b0, eff_role}, 4'h0);
        @(negedge clk);
        check("R11 bus pins free", {2'b0, out1_oe, out2_oe}, 4'h0);
        check("R10 interrupt pin", {3'b0, out3_oe}, 4'h1);
        check("R7 condet disabled", {3'b0, adr_oe}, 4'h0);
        irq_req = 1'b0; port_lvl = 2'b01; addr_lvl = 2'b10;
        @(negedge clk);
        check("R10 interrupt released", {3'b0, out3_oe}, 4'h0);
        check("R5 strap change ignored", {2'b0, eff_role}, 4'h0);
        check("R3 mode held after strap change", {2'b0, reg_mode, addr_bit6}, 4'h3);
        role_wr = 1'b1; role_wr_val = 2'b01;
        @(negedge clk);
        role_wr = 1'b0;
        check("R5 write host", {2'b0, eff_role}, 4'h1);
        role_wr = 1'b1; role_wr_val = 2'b11;
        @(negedge clk);
        role_wr = 1'b0;
        check("R5 reserved write ignored", {2'b0, eff_role}, 4'h1);
        role_wr = 1'b1; role_wr_val = 2'b10;
        @(negedge clk);
        role_wr = 1'b0;
        check("R5 write dual", {2'b0, eff_role}, 4'h2);
        condet_dis = 1'b0; attached = 1'b0;
        @(negedge clk);
        check("R7 condet enabled by register", {3'b0, adr_oe}, 4'h1);
        check("R8 condet low when detached", {3'b0, adr_out}, 4'h0);
        condet_dis = 1'b1;
        @(negedge clk);
        check("R7 condet disabled again", {3'b0, adr_oe}, 4'h0);

        // Register mode, address low, port floating
        boot(2'b00, 2'b11);
        check("R1 not ready at LAT-1 second boot", {3'b0, strap_ready}, 4'h0);
        @(negedge clk);
        check("R3 low address", {2'b0, reg_mode, addr_bit6}, 4'h2);
        check("R4 floating port -> dual", {2'b0, eff_role}, 4'h2);

        finish_run();
    end
endmodule